// File: doc/BRIEF.md
# Dual Controller Port Receiver

This block gives a processor access to two game-controller ports through a small register window. Each port has a control register, a status register and a 32-bit receive latch that is read as two 16-bit halves. Software starts a transfer by setting the send bit of a port. A fixed time later the port takes a 32-bit controller word from its parallel input, raises a data-ready flag and requests an interrupt. Reading the lower half of the latch acknowledges the word.

The serial link to the controller is not modelled. The word is taken from a parallel bus when the transfer completes. In that word, bits 31:28 carry a device type code (0xF six-button pad, 0xE multi-tap, 0xD mouse, 0x0 nothing attached) and the button and direction bits are active low. The block passes these bits through without changing them. The transfer delay is a cycle count derived from the clock frequency and the transfer time in microseconds.

Top module: `gamepad_port_if`

## Requirements
- R1: After reset both status words read 0, `irq` is low and `rdata` is 0.
- R2: Address bit 7 selects the port and address bit 6 selects status (0) or latch (1); other address bits have no effect. The status word holds data-ready at bit 3 and the stored control bits 2:0 mirrored at bits 6:4; all other bits are 0.
- R3: A control write stores only `wdata[2:0]` (bit 0 send, bit 1 multi-tap enable, bit 2 receiver enable). A transfer starts only when a write sets bit 0 while the stored bit 0 is 0. A write that leaves bit 0 at 1, or writes it as 0, starts nothing.
- R4: While a transfer is in flight, a new 0-to-1 edge on bit 0 is ignored and the running transfer keeps its original completion time.
- R5: A transfer completes exactly DELAY clock edges after the edge that accepted the start write, where DELAY = (CLK_HZ/1000)*XFER_US/1000. At completion data-ready is set and stored control bit 0 is cleared; the other control bits are kept.
- R6: A latch read with address bit 1 at 0 returns latch bits 15:0 and clears data-ready. With address bit 1 at 1 it returns bits 31:16 and leaves data-ready unchanged.
- R7: `irq` is the OR of the two ports' data-ready flags. It stays high until both have been cleared.
- R8: Writes to latch addresses (address bit 6 at 1) change no latch, no status and no control state, and start no transfer.
- R9: The latch holds the value of the port's pad input at the completion edge, not at the start.
- R10: If a completion and a low-half read of the same port fall on the same edge, the read returns the old latch value and data-ready ends up set.
- R11: `rdata` is registered. It takes the addressed value on the edge after `rd_en` and holds it while `rd_en` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 8 | Register address |
| wdata | input | DATA_W | Write data |
| rdata | output | DATA_W | Registered read data |
| pad0_word | input | WORD_W | Controller word presented to port 0 |
| pad1_word | input | WORD_W | Controller word presented to port 1 |
| irq | output | 1 | Data-ready interrupt request |

## Verification
The bench sets CLK_HZ to 10 MHz and XFER_US to 2, which gives a 20-cycle transfer. At that size every completion can be hit on its exact edge: the last cycle before data-ready rises, the first cycle after, and a low-half read that lands on the completion edge. The short delay also leaves room for a sweep of all 256 addresses, which checks that only bits 7, 6 and 1 take part in decoding. It also allows repeated transfers on both ports with every device-type code and a walking active-low button bit. Start edges are placed in the middle of running transfers to show that they are ignored, and the pad input is changed after the start to show that the word is captured at completion.

// File: rtl/gp_pkg.sv
package gp_pkg;
  localparam int PORT_ABIT  = 7;
  localparam int DATA_ABIT  = 6;
  localparam int HALF_ABIT  = 1;
  localparam int READY_SBIT = 3;
  localparam int MIRROR_LSB = 4;
  localparam int CTRL_W     = 3;

  typedef struct packed {
    logic rx_en;
    logic mtap_en;
    logic send;
  } gp_ctrl_t;
endpackage

// File: rtl/gp_xfer_timer.sv
module gp_xfer_timer #(
  parameter int DELAY_CYC = 20
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  output logic busy,
  output logic done
);
  localparam int CW = (DELAY_CYC > 1) ? $clog2(DELAY_CYC) : 1;
  localparam logic [CW-1:0] LOAD = CW'(DELAY_CYC - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0;
      cnt  <= '0;
    end else if (start && !busy) begin
      busy <= 1'b1;
      cnt  <= LOAD;
    end else if (busy) begin
      if (cnt == '0) busy <= 1'b0;
      else           cnt  <= cnt - 1'b1;
    end
  end

  assign done = busy && (cnt == '0);
endmodule

// File: rtl/gp_port_channel.sv
module gp_port_channel
  import gp_pkg::*;
#(
  parameter int WORD_W    = 32,
  parameter int DATA_W    = 16,
  parameter int DELAY_CYC = 20
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ctrl_we,
  input  gp_ctrl_t          ctrl_wdata,
  input  logic              lo_rd,
  input  logic [WORD_W-1:0] pad_word,
  output logic [WORD_W-1:0] latch,
  output logic              ready,
  output logic              busy,
  output logic [DATA_W-1:0] status
);
  gp_ctrl_t ctrl_q;
  logic     start;
  logic     done;

  // a start needs a fresh 0->1 edge and an idle timer
  assign start = ctrl_we && ctrl_wdata.send && !ctrl_q.send && !busy;

  gp_xfer_timer #(.DELAY_CYC(DELAY_CYC)) u_timer (
    .clk  (clk),
    .rst  (rst),
    .start(start),
    .busy (busy),
    .done (done)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= '0;
      ready  <= 1'b0;
      latch  <= '0;
    end else begin
      if (ctrl_we) ctrl_q <= ctrl_wdata;
      if (done)    ctrl_q.send <= 1'b0;
      if (done) begin
        latch <= pad_word;
        ready <= 1'b1;
      end else if (lo_rd) begin
        ready <= 1'b0;
      end
    end
  end

  always_comb begin
    status = '0;
    status[READY_SBIT] = ready;
    status[MIRROR_LSB +: CTRL_W] = ctrl_q;
  end
endmodule

// File: rtl/gp_rd_mux.sv
module gp_rd_mux #(
  parameter int NPORT  = 2,
  parameter int WORD_W = 32,
  parameter int DATA_W = 16,
  localparam int PW    = (NPORT > 1) ? $clog2(NPORT) : 1
) (
  input  logic [PW-1:0]                  port_sel,
  input  logic                           data_sel,
  input  logic                           hi_sel,
  input  logic [NPORT-1:0][WORD_W-1:0]   latch_v,
  input  logic [NPORT-1:0][DATA_W-1:0]   status_v,
  output logic [DATA_W-1:0]              rd_val
);
  always_comb begin
    if (!data_sel)   rd_val = status_v[port_sel];
    else if (hi_sel) rd_val = latch_v[port_sel][WORD_W-1 -: DATA_W];
    else             rd_val = latch_v[port_sel][DATA_W-1:0];
  end
endmodule

// File: rtl/gamepad_port_if.sv
module gamepad_port_if
  import gp_pkg::*;
#(
  parameter int CLK_HZ  = 21_477_272,
  parameter int XFER_US = 1000,
  parameter int WORD_W  = 32,
  parameter int DATA_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [7:0]        addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  input  logic [WORD_W-1:0] pad0_word,
  input  logic [WORD_W-1:0] pad1_word,
  output logic              irq
);
  localparam int NPORT     = 2;
  localparam int DELAY_RAW = (CLK_HZ / 1000) * XFER_US / 1000;
  localparam int DELAY_CYC = (DELAY_RAW < 1) ? 1 : DELAY_RAW;

  logic [NPORT-1:0][WORD_W-1:0] pad_v;
  logic [NPORT-1:0][WORD_W-1:0] latch_v;
  logic [NPORT-1:0][DATA_W-1:0] status_v;
  logic [NPORT-1:0]             rdy_vec;
  logic [NPORT-1:0]             bsy_vec;
  logic [DATA_W-1:0]            rd_val;
  logic                         spare_unused;

  assign pad_v[0] = pad0_word;
  assign pad_v[1] = pad1_word;
  assign spare_unused = ^{addr[5:2], addr[0], wdata[DATA_W-1:CTRL_W]};

  for (genvar p = 0; p < NPORT; p++) begin : g_port
    logic hit;
    assign hit = (addr[PORT_ABIT] == 1'(p));

    gp_port_channel #(
      .WORD_W   (WORD_W),
      .DATA_W   (DATA_W),
      .DELAY_CYC(DELAY_CYC)
    ) u_chan (
      .clk       (clk),
      .rst       (rst),
      .ctrl_we   (wr_en && hit && !addr[DATA_ABIT]),
      .ctrl_wdata(gp_ctrl_t'(wdata[CTRL_W-1:0])),
      .lo_rd     (rd_en && hit && addr[DATA_ABIT] && !addr[HALF_ABIT]),
      .pad_word  (pad_v[p]),
      .latch     (latch_v[p]),
      .ready     (rdy_vec[p]),
      .busy      (bsy_vec[p]),
      .status    (status_v[p])
    );
  end

  gp_rd_mux #(
    .NPORT (NPORT),
    .WORD_W(WORD_W),
    .DATA_W(DATA_W)
  ) u_mux (
    .port_sel(addr[PORT_ABIT]),
    .data_sel(addr[DATA_ABIT]),
    .hi_sel  (addr[HALF_ABIT]),
    .latch_v (latch_v),
    .status_v(status_v),
    .rd_val  (rd_val)
  );

  always_ff @(posedge clk) begin
    if (rst)        rdata <= '0;
    else if (rd_en) rdata <= rd_val;
  end

  assign irq = |rdy_vec;
endmodule

// File: rtl/gp_port_if_chk.sv
module gp_port_if_chk #(
  parameter int DATA_W = 16,
  parameter int NPORT  = 2
) (
  input logic              clk,
  input logic              rst,
  input logic              wr_en,
  input logic              rd_en,
  input logic              a_port,
  input logic              a_data,
  input logic              a_half,
  input logic [DATA_W-1:0] rdata,
  input logic              irq,
  input logic [NPORT-1:0]  rdy,
  input logic [NPORT-1:0]  bsy
);
  // R1
  reset_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!irq && rdata == '0));

  // R11
  rdata_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(rd_en) |-> $stable(rdata));

  // R7
  irq_drop_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(irq) |-> $past(rd_en));

  for (genvar p = 0; p < NPORT; p++) begin : g_chk
    // R5
    ready_from_xfer_chk: assert property (@(posedge clk) disable iff (rst)
      $rose(rdy[p]) |-> $past(bsy[p]));

    // R3
    start_by_write_chk: assert property (@(posedge clk) disable iff (rst)
      $rose(bsy[p]) |-> $past(wr_en));

    // R6
    hi_read_keeps_chk: assert property (@(posedge clk) disable iff (rst)
      (rd_en && a_port == 1'(p) && a_data && a_half && rdy[p]) |=> rdy[p]);
  end
endmodule

bind gamepad_port_if gp_port_if_chk #(.DATA_W(DATA_W), .NPORT(NPORT)) u_chk (
  .clk   (clk),
  .rst   (rst),
  .wr_en (wr_en),
  .rd_en (rd_en),
  .a_port(addr[7]),
  .a_data(addr[6]),
  .a_half(addr[1]),
  .rdata (rdata),
  .irq   (irq),
  .rdy   (rdy_vec),
  .bsy   (bsy_vec)
);

// File: tb/tb_gamepad_port_if.sv
module tb_gamepad_port_if;
  localparam int CLK_PERIOD = 10;
  localparam int CLK_HZ     = 10_000_000;
  localparam int XFER_US    = 2;
  localparam int DLY        = XFER_US * (CLK_HZ / 1_000_000);

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic        rd_en = 1'b0;
  logic [7:0]  addr = '0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic [31:0] pad [2];
  logic        irq;

  int n_chk = 0;
  int n_err = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  gamepad_port_if #(.CLK_HZ(CLK_HZ), .XFER_US(XFER_US)) dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .pad0_word(pad[0]), .pad1_word(pad[1]),
    .irq(irq)
  );

  function automatic logic [7:0] a_st(input int p);  return (p != 0) ? 8'h80 : 8'h00; endfunction
  function automatic logic [7:0] a_lo(input int p);  return a_st(p) | 8'h40; endfunction
  function automatic logic [7:0] a_hi(input int p);  return a_st(p) | 8'h42; endfunction
  function automatic logic [15:0] st(input logic [2:0] c, input logic r);
    return {9'b0, c, r, 3'b000};
  endfunction
  function automatic logic [3:0] id_of(input int k);
    case (k)
      0: return 4'hF;
      1: return 4'hE;
      2: return 4'hD;
      default: return 4'h0;
    endcase
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // all tasks enter and leave at a falling edge
  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask
  task automatic wr(input logic [7:0] a, input logic [15:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask
  task automatic rd(input logic [7:0] a, output logic [15:0] d);
    rd_en = 1'b1; addr = a;
    @(negedge clk);
    rd_en = 1'b0;
    d = rdata;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      n_chk++; n_err++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    logic [15:0] v;
    logic [31:0] w;
    logic [31:0] old0;
    pad[0] = '0; pad[1] = '0;
    repeat (5) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    chk("R1 rdata", rdata, 0);
    chk("R1 irq", irq, 0);
    rd(a_st(0), v); chk("R1 status0", v, 0);
    rd(a_st(1), v); chk("R1 status1", v, 0);

    // R5 R6 R7 R9 per port, per device code
    for (int p = 0; p < 2; p++) begin
      for (int k = 0; k < 4; k++) begin
        logic [2:0] c;
        c = {k[0], k[1], 1'b1};
        w = {id_of(k), ~(28'h1 << (k*7 + p))};
        pad[p] = ~w;
        wr(a_st(p), {13'b0, c});
        pad[p] = w;
        idle(DLY - 1);
        rd(a_st(p), v); chk("R5 not yet complete", v, st(c, 1'b0));
        rd(a_st(p), v); chk("R5 complete", v, st({c[2:1], 1'b0}, 1'b1));
        chk("R7 irq raised", irq, 1);
        rd(a_hi(p), v); chk("R6 high half", v, w[31:16]);
        rd(a_st(p), v); chk("R6 high read keeps ready", v, st({c[2:1], 1'b0}, 1'b1));
        rd(a_lo(p), v); chk("R9 low half captured at completion", v, w[15:0]);
        rd(a_st(p), v); chk("R6 low read clears ready", v, st({c[2:1], 1'b0}, 1'b0));
        chk("R7 irq dropped", irq, 0);
      end
    end

    // R3 rewrite of a set send bit does not restart
    wr(a_st(0), 16'h0001);
    idle(5);
    wr(a_st(0), 16'h0001);
    idle(DLY - 7);
    rd(a_st(0), v); chk("R3 busy at edge DLY", v, st(3'b001, 1'b0));
    rd(a_st(0), v); chk("R3 no restart", v, st(3'b000, 1'b1));
    rd(a_lo(0), v); chk("R3 latch", v, pad[0][15:0]);

    // R4 new edge during flight ignored
    wr(a_st(1), 16'h0001);
    idle(3);
    wr(a_st(1), 16'h0000);
    wr(a_st(1), 16'h0001);
    idle(DLY - 6);
    rd(a_st(1), v); chk("R4 in flight", v, st(3'b001, 1'b0));
    rd(a_st(1), v); chk("R4 original completion time", v, st(3'b000, 1'b1));
    rd(a_lo(1), v);
    // R5 send bit cleared by hardware, so a new write of 1 starts
    wr(a_st(1), 16'h0001);
    idle(DLY - 1);
    rd(a_st(1), v); chk("R5 restart pending", v, st(3'b001, 1'b0));
    rd(a_st(1), v); chk("R5 restart completes", v, st(3'b000, 1'b1));
    rd(a_lo(1), v);

    // R3 no send bit: only bits 2:0 stored, no transfer
    wr(a_st(0), 16'hFFFE);
    idle(DLY + 3);
    rd(a_st(0), v); chk("R3 no transfer without send", v, st(3'b110, 1'b0));
    chk("R3 irq stays low", irq, 0);

    // R8 data writes ignored
    pad[0] = 32'hF00A_5A5A;
    wr(a_lo(0), 16'h0001);
    idle(DLY + 2);
    rd(a_st(0), v); chk("R8 data write starts nothing", v, st(3'b110, 1'b0));
    wr(a_st(0), 16'h0001);
    idle(DLY + 1);
    wr(a_lo(0), 16'h1234);
    wr(a_hi(0), 16'hABCD);
    rd(a_st(0), v); chk("R8 status unchanged", v, st(3'b000, 1'b1));
    rd(a_hi(0), v); chk("R8 latch high unchanged", v, 16'hF00A);
    rd(a_lo(0), v); chk("R8 latch low unchanged", v, 16'h5A5A);

    // R7 OR of both flags
    pad[0] = 32'hD000_0F0F; pad[1] = 32'h0FFF_FFFF;
    wr(a_st(0), 16'h0001);
    wr(a_st(1), 16'h0001);
    idle(DLY + 2);
    chk("R7 both ready", irq, 1);
    rd(a_lo(0), v); chk("R7 port0 low", v, 16'h0F0F);
    chk("R7 irq held by port1", irq, 1);
    rd(a_lo(1), v); chk("R7 port1 low", v, 16'hFFFF);
    chk("R7 irq clear", irq, 0);

    // R10 completion collides with low read
    old0 = 32'hD000_0F0F;
    pad[0] = 32'hE123_C3C3;
    wr(a_st(0), 16'h0001);
    idle(DLY - 1);
    rd(a_lo(0), v); chk("R10 old latch returned", v, old0[15:0]);
    rd(a_st(0), v); chk("R10 ready set wins", v, st(3'b000, 1'b1));
    rd(a_lo(0), v); chk("R10 new latch", v, 16'hC3C3);

    // R11 rdata holds while idle and across writes
    idle(4);
    chk("R11 hold idle", rdata, 16'hC3C3);
    wr(a_st(1), 16'h0004);
    chk("R11 hold across write", rdata, 16'hC3C3);

    // R2 address sweep
    wr(a_st(0), 16'h0007);
    idle(DLY + 1);
    for (int a = 0; a < 256; a++) begin
      logic [7:0] aa;
      aa = 8'(a);
      if (!aa[6]) begin
        rd(aa, v);
        chk("R2 status decode", v, aa[7] ? st(3'b100, 1'b0) : st(3'b110, 1'b1));
      end else if (aa[1]) begin
        rd(aa, v);
        chk("R2 high decode", v, aa[7] ? 16'h0FFF : 16'hE123);
      end
    end

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule